// File: doc/BRIEF.md
# System Activity Power-State Manager

This block is the policy engine that decides how much of a system stays awake. It chooses one of three operating states: full-speed Active, reduced Low-Power, and Suspend. The inputs it watches are user-interface activity, a network-busy level, a pulse marking the end of a data-collection pass, an explicit suspend request and an external wake event. A tick input, typically one pulse per second, drives two timers. The first is an inactivity timer that runs while Active. The second is a collection-period timer that runs while the system idles in Low-Power, or sleeps after having been in Low-Power.

For each state the block drives a clock-frequency select code, a display/graphics enable, a memory self-refresh request and a deep-sleep request. The clock generators and the display hardware sit outside and act on these controls. A one-bit record of where Suspend was entered from decides where a wake lands. A sleep entered straight from Active wakes back into Active. A sleep entered from Low-Power wakes into Low-Power, either on a wake event or when the collection period runs out.

Top module: `pwr_policy_mgr`

## Requirements
- R1: After reset the state is Active and the outputs read freq_sel=2'b10, disp_en=1, mem_sr_req=0, deep_sleep_req=0.
- R2: In Active, once IDLE_TICKS tick pulses have been counted with no user activity, and net_busy and ui_act are both low on the next cycle, the state becomes Low-Power. Cycles without a tick do not advance the count. Low-Power outputs are freq_sel=2'b01, disp_en=0, mem_sr_req=0, deep_sleep_req=0.
- R3: Any ui_act cycle clears the inactivity count. While net_busy is high, Active is held however long the system stays idle.
- R4: In Low-Power, ui_act moves the state to Active on the next edge, and it takes precedence over collect_done and suspend_req.
- R5: In Low-Power, collect_done or suspend_req moves the state to Suspend. Suspend outputs are freq_sel=2'b00, disp_en=0, mem_sr_req=1, deep_sleep_req=1.
- R6: In Suspend, wake_evt returns to Active if Suspend was entered from Active, and to Low-Power if it was entered from Low-Power.
- R7: In Active, suspend_req moves the state to Suspend on the next edge, and it takes precedence over an expired inactivity timer.
- R8: The collection timer is cleared on entry to Suspend. In a Suspend entered from Low-Power it counts ticks, and after COLL_TICKS ticks it returns the state to Low-Power on the following edge. In a Suspend entered from Active it does not count.
- R9: In Suspend, ui_act, collect_done and suspend_req have no effect.
- R10: The outputs are registered from the state and change on the clock edge after the state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase pulse, one cycle per timer unit |
| ui_act | input | 1 | User-interface activity seen this cycle |
| net_busy | input | 1 | Network activity is high |
| collect_done | input | 1 | Pulse: a data-collection pass finished |
| suspend_req | input | 1 | Request to enter Suspend |
| wake_evt | input | 1 | External wake event (network or sensor) |
| freq_sel | output | 2 | Frequency code: 10 high, 01 low, 00 stopped |
| disp_en | output | 1 | Display and graphics enable |
| mem_sr_req | output | 1 | Memory self-refresh request |
| deep_sleep_req | output | 1 | Processor deep-sleep request |

## Verification
A wrong state register shows up as a wrong output code exactly one edge later, because the outputs are a registered decode of the state. An inactivity count that is off by one moves the Low-Power entry by one cycle, and the bench samples on both sides of that edge. A wrong wake-origin bit has no visible effect until a wake occurs: it either sends the system to the wrong state on a wake event, or causes a timer wake where none should happen. Both cases show two edges after the wake.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_LOWPWR  = 2'd1,
    ST_SUSPEND = 2'd2
  } pwr_state_e;

  localparam logic [1:0] FREQ_HIGH = 2'b10;
  localparam logic [1:0] FREQ_LOW  = 2'b01;
  localparam logic [1:0] FREQ_STOP = 2'b00;

  typedef struct packed {
    logic [1:0] freq;
    logic       disp;
    logic       self_ref;
    logic       deep_sleep;
  } pwr_ctl_t;

  function automatic pwr_ctl_t ctl_for(input pwr_state_e s);
    pwr_ctl_t c;
    case (s)
      ST_LOWPWR:  c = '{freq: FREQ_LOW,  disp: 1'b0, self_ref: 1'b0, deep_sleep: 1'b0};
      ST_SUSPEND: c = '{freq: FREQ_STOP, disp: 1'b0, self_ref: 1'b1, deep_sleep: 1'b1};
      default:    c = '{freq: FREQ_HIGH, disp: 1'b1, self_ref: 1'b0, deep_sleep: 1'b0};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pwr_tick_timer.sv
module pwr_tick_timer #(
  parameter int LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic cnt_en,
  output logic expired
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_upd;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (cnt_en && (cnt_q != LIM))
      cnt_d = cnt_q + 1'b1;
  end

  assign cnt_upd = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_upd)
      cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == LIM);
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ui_act,
  input  logic       net_busy,
  input  logic       collect_done,
  input  logic       suspend_req,
  input  logic       wake_evt,
  input  logic       idle_exp,
  input  logic       coll_exp,
  output pwr_state_e state_q,
  output logic       from_act_q,
  output logic       susp_entry
);
  pwr_state_e state_d;
  logic       state_upd;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_ACTIVE: begin
        if (suspend_req)
          state_d = ST_SUSPEND;
        else if (idle_exp && !net_busy && !ui_act)
          state_d = ST_LOWPWR;
      end
      ST_LOWPWR: begin
        if (ui_act)
          state_d = ST_ACTIVE;
        else if (collect_done || suspend_req)
          state_d = ST_SUSPEND;
      end
      ST_SUSPEND: begin
        if (wake_evt)
          state_d = from_act_q ? ST_ACTIVE : ST_LOWPWR;
        else if (coll_exp && !from_act_q)
          state_d = ST_LOWPWR;
      end
      default: state_d = ST_ACTIVE;
    endcase
  end

  assign state_upd  = (state_d != state_q);
  assign susp_entry = (state_d == ST_SUSPEND) && (state_q != ST_SUSPEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state_q <= ST_ACTIVE;
    else if (state_upd)
      state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      from_act_q <= 1'b0;
    else if (susp_entry)
      from_act_q <= (state_q == ST_ACTIVE);
  end
endmodule

// File: rtl/pwr_ctl_reg.sv
module pwr_ctl_reg
  import pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pwr_state_e state,
  output pwr_ctl_t   ctl_q
);
  pwr_ctl_t ctl_d;
  logic     ctl_upd;

  assign ctl_d   = ctl_for(state);
  assign ctl_upd = (ctl_d != ctl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctl_q <= ctl_for(ST_ACTIVE);
    else if (ctl_upd)
      ctl_q <= ctl_d;
  end
endmodule

// File: rtl/pwr_policy_mgr.sv
module pwr_policy_mgr
  import pwr_pkg::*;
#(
  parameter int IDLE_TICKS = 10,
  parameter int COLL_TICKS = 1800
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       ui_act,
  input  logic       net_busy,
  input  logic       collect_done,
  input  logic       suspend_req,
  input  logic       wake_evt,
  output logic [1:0] freq_sel,
  output logic       disp_en,
  output logic       mem_sr_req,
  output logic       deep_sleep_req
);
  pwr_state_e state_q;
  logic       from_act_q;
  logic       susp_entry;
  logic       idle_exp, coll_exp;
  logic       idle_clr, idle_en;
  logic       coll_clr, coll_en;
  pwr_ctl_t   ctl_q;

  assign idle_clr = ui_act || (state_q != ST_ACTIVE);
  assign idle_en  = tick && (state_q == ST_ACTIVE);

  assign coll_clr = (state_q == ST_ACTIVE) || susp_entry;
  assign coll_en  = tick && ((state_q == ST_LOWPWR) ||
                             ((state_q == ST_SUSPEND) && !from_act_q));

  pwr_tick_timer #(.LIMIT(IDLE_TICKS)) u_idle_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (idle_clr),
    .cnt_en  (idle_en),
    .expired (idle_exp)
  );

  pwr_tick_timer #(.LIMIT(COLL_TICKS)) u_coll_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (coll_clr),
    .cnt_en  (coll_en),
    .expired (coll_exp)
  );

  pwr_state_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .ui_act       (ui_act),
    .net_busy     (net_busy),
    .collect_done (collect_done),
    .suspend_req  (suspend_req),
    .wake_evt     (wake_evt),
    .idle_exp     (idle_exp),
    .coll_exp     (coll_exp),
    .state_q      (state_q),
    .from_act_q   (from_act_q),
    .susp_entry   (susp_entry)
  );

  pwr_ctl_reg u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .state (state_q),
    .ctl_q (ctl_q)
  );

  assign freq_sel       = ctl_q.freq;
  assign disp_en        = ctl_q.disp;
  assign mem_sr_req     = ctl_q.self_ref;
  assign deep_sleep_req = ctl_q.deep_sleep;
endmodule

// File: rtl/pwr_policy_chk.sv
module pwr_policy_chk
  import pwr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       ui_act,
  input logic       wake_evt,
  input logic       suspend_req,
  input logic       tick,
  input logic       coll_exp,
  input logic [1:0] state_q,
  input logic       from_act_q,
  input logic [1:0] freq_sel,
  input logic       mem_sr_req,
  input logic       deep_sleep_req
);

  AST_LOW_UI_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOWPWR) && ui_act |=> (state_q == ST_ACTIVE)); // R4

  AST_ACT_SUSP_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACTIVE) && suspend_req |=> (state_q == ST_SUSPEND)); // R7

  AST_WAKE_TO_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SUSPEND) && wake_evt && from_act_q |=> (state_q == ST_ACTIVE)); // R6

  AST_WAKE_TO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SUSPEND) && wake_evt && !from_act_q |=> (state_q == ST_LOWPWR)); // R6

  AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SUSPEND) && !wake_evt && !coll_exp && !tick |=> (state_q == ST_SUSPEND)); // R9

  AST_SUSP_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_SUSPEND) |-> mem_sr_req && deep_sleep_req && (freq_sel == FREQ_STOP)); // R10

endmodule

bind pwr_policy_mgr pwr_policy_chk u_chk (.*);

// File: tb/pwr_policy_mgr_test.sv
module pwr_policy_mgr_test;
  localparam int IDLE = 4;
  localparam int COLL = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick, ui_act, net_busy, collect_done, suspend_req, wake_evt;
  logic [1:0] freq_sel;
  logic       disp_en, mem_sr_req, deep_sleep_req;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pwr_policy_mgr #(.IDLE_TICKS(IDLE), .COLL_TICKS(COLL)) uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick           (tick),
    .ui_act         (ui_act),
    .net_busy       (net_busy),
    .collect_done   (collect_done),
    .suspend_req    (suspend_req),
    .wake_evt       (wake_evt),
    .freq_sel       (freq_sel),
    .disp_en        (disp_en),
    .mem_sr_req     (mem_sr_req),
    .deep_sleep_req (deep_sleep_req)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // mode: 0 Active, 1 Low-Power, 2 Suspend
  task automatic expect_mode(input string req, input int mode);
    logic [4:0] exp_v, got_v;
    case (mode)
      1:       exp_v = {2'b01, 1'b0, 1'b0, 1'b0};
      2:       exp_v = {2'b00, 1'b0, 1'b1, 1'b1};
      default: exp_v = {2'b10, 1'b1, 1'b0, 1'b0};
    endcase
    got_v = {freq_sel, disp_en, mem_sr_req, deep_sleep_req};
    checks++;
    if (got_v !== exp_v) begin
      fails++;
      $display("FAIL %s: outputs %b expected %b", req, got_v, exp_v);
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; ui_act = 1'b0; net_busy = 1'b0;
    collect_done = 1'b0; suspend_req = 1'b0; wake_evt = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    expect_mode("R1", 0);
    cyc(2);
    expect_mode("R1", 0);

    // R3: idle gaps up to the limit, each broken by UI activity
    for (int g = 1; g <= IDLE; g++) begin
      ui_act = 1'b1; cyc(1);
      ui_act = 1'b0; tick = 1'b1; cyc(g);
      expect_mode("R3", 0);
    end
    ui_act = 1'b1; cyc(1); ui_act = 1'b0;
    net_busy = 1'b1; cyc(20);
    expect_mode("R3", 0);
    net_busy = 1'b0; cyc(1);
    expect_mode("R10", 0);
    cyc(1);
    expect_mode("R2", 1);

    // R2: cycles without tick do not count; exact tick count to Low-Power
    ui_act = 1'b1; tick = 1'b0; cyc(1); ui_act = 1'b0;
    cyc(12);
    expect_mode("R2", 0);
    tick = 1'b1; cyc(5);
    expect_mode("R2", 0);
    cyc(1);
    expect_mode("R2", 1);

    // R4: UI beats collect_done in Low-Power
    ui_act = 1'b1; collect_done = 1'b1; cyc(1);
    ui_act = 1'b0; collect_done = 1'b0; cyc(1);
    expect_mode("R4", 0);
    cyc(4);
    expect_mode("R2", 0);
    cyc(1);
    expect_mode("R2", 1);

    // R5: collect_done from Low-Power enters Suspend
    tick = 1'b0;
    collect_done = 1'b1; cyc(1); collect_done = 1'b0;
    expect_mode("R10", 1);
    cyc(1);
    expect_mode("R5", 2);

    // R9: inputs ignored while suspended
    ui_act = 1'b1; collect_done = 1'b1; suspend_req = 1'b1; cyc(6);
    ui_act = 1'b0; collect_done = 1'b0; suspend_req = 1'b0;
    expect_mode("R9", 2);

    // R6: wake returns to Low-Power when entered from Low-Power
    wake_evt = 1'b1; cyc(1); wake_evt = 1'b0; cyc(1);
    expect_mode("R6", 1);

    // R8: collection timer wake from a Low-Power-origin Suspend
    suspend_req = 1'b1; tick = 1'b1; cyc(1); suspend_req = 1'b0;
    cyc(COLL + 1);
    expect_mode("R8", 2);
    cyc(1);
    expect_mode("R8", 1);

    // R7: suspend_req beats expired inactivity timer in Active
    ui_act = 1'b1; cyc(1); ui_act = 1'b0; net_busy = 1'b1; cyc(6);
    expect_mode("R4", 0);
    suspend_req = 1'b1; net_busy = 1'b0; cyc(1); suspend_req = 1'b0;
    cyc(1);
    expect_mode("R7", 2);

    // R8: no timer wake from an Active-origin Suspend
    cyc(20);
    expect_mode("R8", 2);

    // R6: wake returns to Active when entered from Active
    wake_evt = 1'b1; cyc(1); wake_evt = 1'b0;
    expect_mode("R10", 2);
    cyc(1);
    expect_mode("R6", 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule